// File: doc/BRIEF.md
# LCD Raster Timing Generator

This block produces the scan timing for a parallel RGB panel: a horizontal and a vertical position counter, horizontal and vertical sync, and a data-enable that marks the visible window. Every timing value is a programmable input. The sync widths, the line and frame totals, and the first and last-plus-one counts of the active window on each axis are all measured from the leading edge of sync. Only the low 10 bits of each count field are used.

A configuration field chooses the active level of each of the three timing outputs. The raster starts when enable is set and disable is clear. A disable request does not cut off the frame being scanned. The raster runs to the last pixel of the current frame, then returns to idle and raises a stopped flag that holds until it is explicitly cleared. Start-of-frame and end-of-frame pulses, each with its own enable, let a frame-buffer fetch engine or an interrupt controller follow the scan.

Top module: `lcd_raster_gen`

## Requirements
- R1: After reset the block is idle. Both counters read 0, the stopped flag is 0, and hsync, vsync and data-enable sit at their inactive levels.
- R2: While running, the horizontal count steps by one each cycle from 0 to Htotal-1 and then wraps to 0. The vertical count steps by one on each horizontal wrap and wraps after Vtotal-1. Htotal is in bits 31:16 of the totals word and Vtotal is in bits 15:0.
- R3: While running, hsync is active when hcount < hsync width, and vsync is active when vcount < vsync width.
- R4: While running, data-enable is active when hstart <= hcount < hend and vstart <= vcount < vend. Each window word carries its start in bits 31:16 and its end in bits 15:0.
- R5: Polarity bit 0 inverts hsync, bit 1 inverts vsync and bit 2 inverts data-enable. A set bit means the output is active-low. The inversion also applies to the idle level.
- R6: In idle, a cycle with enable=1 and disable=0 starts the raster. The next cycle shows hcount=0 and vcount=0.
- R7: A disable seen at any point during a frame lets that frame finish in full. After its last pixel the block goes idle, and both counters and data-enable stay at rest.
- R8: The stopped flag reads 1 from the first idle cycle after a disable stop. It stays 1 until a status-clear pulse, and it reads 0 in the cycle after that pulse.
- R9: While disable is 1, an idle block does not start, even with enable set.
- R10: A one-cycle start-of-frame pulse appears at hcount=0, vcount=0 when its enable is set. A one-cycle end-of-frame pulse appears at the last pixel of the frame when its enable is set. A pulse whose enable is clear stays low.
- R11: Bits 15:10 of every 16-bit count field, and of the sync width inputs, have no effect on the timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-rate clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_enable_i | input | 1 | Run request |
| ctl_disable_i | input | 1 | Stop request, acted on at frame end |
| status_clr_i | input | 1 | Clears the stopped flag |
| sof_irq_en_i | input | 1 | Enables the start-of-frame pulse |
| eof_irq_en_i | input | 1 | Enables the end-of-frame pulse |
| pol_cfg_i | input | 3 | Inversion of {de, vsync, hsync} |
| hsync_len_i | input | 16 | Hsync width in pixels (low 10 bits used) |
| vsync_len_i | input | 16 | Vsync width in lines (low 10 bits used) |
| totals_i | input | 32 | {Htotal, Vtotal} |
| hwin_i | input | 32 | {hstart, hend} |
| vwin_i | input | 32 | {vstart, vend} |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| de_o | output | 1 | Data enable |
| hcount_o | output | 10 | Horizontal position |
| vcount_o | output | 10 | Vertical position |
| sof_o | output | 1 | Start-of-frame pulse |
| eof_o | output | 1 | End-of-frame pulse |
| stopped_o | output | 1 | Stopped status flag |

## Verification
The bound checker checks a set of rules on every cycle:
- the horizontal count steps by one until it wraps;
- an idle block holds its counters at zero with data-enable inactive;
- the stopped flag rises together with the drop to idle;
- disable blocks any start;
- the start-of-frame pulse never lasts two cycles.

Only the bench scenarios can show the exact shape of sync and the window edges over whole frames. The same applies to a full final frame after a mid-frame disable, the effect of each polarity bit and pulse enable, and the masking of the upper field bits. The bench shows these by comparing every pixel against a queue of predicted values.

// File: rtl/lcd_raster_pkg.sv
// Shared definitions for the LCD raster timing generator.
// Assumes count fields sit in 16-bit halves of 32-bit words.
package lcd_raster_pkg;
    localparam int FIELD_W = 16;
    localparam int AXES    = 2;
    localparam int AX_H    = 0;
    localparam int AX_V    = 1;

    // One packed pair: upper half and lower half of a 32-bit word
    typedef struct packed {
        logic [FIELD_W-1:0] hi;
        logic [FIELD_W-1:0] lo;
    } pair_t;
endpackage

// File: rtl/lcd_axis_counter.sv
// Position counter for one scan axis.
// Holds at zero while clear is set. Otherwise it steps on each step pulse
// and wraps to zero after reaching total-1.
// Assumes total is at least 1. A total of 0 wraps at the full count range.
module lcd_axis_counter #(
    parameter int CW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          step,
    input  logic [CW-1:0] total,
    output logic [CW-1:0] count,
    output logic          at_last
);
    logic [CW-1:0] count_q;

    // Last position of the axis
    assign at_last = (count_q == CW'(total - 1'b1));
    assign count   = count_q;

    // Advance, wrap or hold the position
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            count_q <= '0;
        end else if (step) begin
            count_q <= at_last ? '0 : CW'(count_q + 1'b1);
        end
    end
endmodule

// File: rtl/lcd_span_decode.sv
// Decodes one axis position into a sync-active flag and a window-active flag.
// The window start is inclusive and the end is exclusive.
// Purely combinational.
module lcd_span_decode #(
    parameter int CW = 10
) (
    input  logic [CW-1:0] count,
    input  logic [CW-1:0] sync_width,
    input  logic [CW-1:0] win_start,
    input  logic [CW-1:0] win_end,
    output logic          sync_act,
    output logic          win_act
);
    // Compare the position against the sync width and the window bounds
    always_comb begin
        sync_act = (count < sync_width);
        win_act  = (count >= win_start) && (count < win_end);
    end
endmodule

// File: rtl/lcd_raster_ctrl.sv
// Run/stop controller.
// Starts the raster on enable without disable.
// Latches a disable request and drops to idle only after the last pixel
// of a frame.
// Keeps a sticky stopped flag, cleared by a status-clear pulse.
// When a stop and a clear land in the same cycle, the stop wins.
module lcd_raster_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic disable_req,
    input  logic status_clr,
    input  logic frame_last,
    output logic run,
    output logic stopped
);
    logic run_q, pend_q, stopped_q, stop_now;

    // Stop at the frame boundary when a request is pending or present
    assign stop_now = run_q && frame_last && (pend_q || disable_req);

    // Run state and pending stop request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= 1'b0;
            pend_q <= 1'b0;
        end else if (!run_q) begin
            pend_q <= 1'b0;
            if (enable && !disable_req) run_q <= 1'b1;
        end else if (stop_now) begin
            run_q  <= 1'b0;
            pend_q <= 1'b0;
        end else if (disable_req) begin
            pend_q <= 1'b1;
        end
    end

    // Sticky stopped flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stopped_q <= 1'b0;
        end else if (stop_now) begin
            stopped_q <= 1'b1;
        end else if (status_clr) begin
            stopped_q <= 1'b0;
        end
    end

    assign run     = run_q;
    assign stopped = stopped_q;
endmodule

// File: rtl/lcd_raster_gen.sv
// LCD raster timing generator, top level.
// Unpacks the timing words, runs one counter and one decoder per axis,
// and applies the polarity to hsync, vsync and data-enable.
// Only the low CW bits of each field are used.
// The configuration inputs are assumed stable while the raster runs.
module lcd_raster_gen
    import lcd_raster_pkg::*;
#(
    parameter int CW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctl_enable_i,
    input  logic          ctl_disable_i,
    input  logic          status_clr_i,
    input  logic          sof_irq_en_i,
    input  logic          eof_irq_en_i,
    input  logic [2:0]    pol_cfg_i,
    input  logic [15:0]   hsync_len_i,
    input  logic [15:0]   vsync_len_i,
    input  logic [31:0]   totals_i,
    input  logic [31:0]   hwin_i,
    input  logic [31:0]   vwin_i,
    output logic          hsync_o,
    output logic          vsync_o,
    output logic          de_o,
    output logic [CW-1:0] hcount_o,
    output logic [CW-1:0] vcount_o,
    output logic          sof_o,
    output logic          eof_o,
    output logic          stopped_o
);
    localparam int NOUT = 3;

    pair_t totals_w, hwin_w, vwin_w;
    logic [AXES-1:0][CW-1:0] tot_w, swid_w, wst_w, wend_w, cnt_w;
    logic [AXES-1:0]         last_w, step_w, sync_w, win_w;
    logic                    run_w, frame_last_w;
    logic [NOUT-1:0]         act_w, out_w;

    // Unpack the timing words and keep the low CW bits of each field
    always_comb begin
        totals_w = totals_i;
        hwin_w   = hwin_i;
        vwin_w   = vwin_i;
        tot_w[AX_H]  = totals_w.hi[CW-1:0];
        tot_w[AX_V]  = totals_w.lo[CW-1:0];
        swid_w[AX_H] = hsync_len_i[CW-1:0];
        swid_w[AX_V] = vsync_len_i[CW-1:0];
        wst_w[AX_H]  = hwin_w.hi[CW-1:0];
        wend_w[AX_H] = hwin_w.lo[CW-1:0];
        wst_w[AX_V]  = vwin_w.hi[CW-1:0];
        wend_w[AX_V] = vwin_w.lo[CW-1:0];
    end

    // Horizontal steps every running cycle; vertical steps on a horizontal wrap
    assign step_w[AX_H] = run_w;
    assign step_w[AX_V] = run_w && last_w[AX_H];
    assign frame_last_w = last_w[AX_H] && last_w[AX_V];

    for (genvar a = 0; a < AXES; a++) begin : g_axis
        lcd_axis_counter #(.CW(CW)) u_cnt (
            .clk     (clk),
            .rst_n   (rst_n),
            .clear   (!run_w),
            .step    (step_w[a]),
            .total   (tot_w[a]),
            .count   (cnt_w[a]),
            .at_last (last_w[a])
        );
        lcd_span_decode #(.CW(CW)) u_dec (
            .count      (cnt_w[a]),
            .sync_width (swid_w[a]),
            .win_start  (wst_w[a]),
            .win_end    (wend_w[a]),
            .sync_act   (sync_w[a]),
            .win_act    (win_w[a])
        );
    end

    lcd_raster_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (ctl_enable_i),
        .disable_req (ctl_disable_i),
        .status_clr  (status_clr_i),
        .frame_last  (frame_last_w),
        .run         (run_w),
        .stopped     (stopped_o)
    );

    // Active levels before polarity: {de, vsync, hsync}
    assign act_w = {run_w && win_w[AX_H] && win_w[AX_V],
                    run_w && sync_w[AX_V],
                    run_w && sync_w[AX_H]};

    for (genvar k = 0; k < NOUT; k++) begin : g_pol
        assign out_w[k] = act_w[k] ^ pol_cfg_i[k];
    end

    assign hsync_o  = out_w[0];
    assign vsync_o  = out_w[1];
    assign de_o     = out_w[2];
    assign hcount_o = cnt_w[AX_H];
    assign vcount_o = cnt_w[AX_V];

    // Frame boundary pulses, each gated by its own enable
    assign sof_o = sof_irq_en_i && run_w && (cnt_w[AX_H] == '0) && (cnt_w[AX_V] == '0);
    assign eof_o = eof_irq_en_i && run_w && frame_last_w;
endmodule

// File: rtl/lcd_raster_chk.sv
// Assertion checker for lcd_raster_gen. It is attached by the bind below.
// Assumes the timing configuration stays stable while the raster runs.
module lcd_raster_chk #(
    parameter int CW = 10
) (
    input logic          clk,
    input logic          rst_n,
    input logic          run,
    input logic          dis,
    input logic [CW-1:0] hcount,
    input logic [CW-1:0] vcount,
    input logic [CW-1:0] htot,
    input logic          de,
    input logic          de_pol,
    input logic          sof,
    input logic          stopped
);
    AST_IDLE_REST: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (hcount == '0) && (vcount == '0) && (de == de_pol)); // R7

    AST_H_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        run && (hcount != CW'(htot - 1'b1)) |=> run && (hcount == CW'($past(hcount) + 1'b1))); // R2

    AST_H_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        run && (hcount == CW'(htot - 1'b1)) |=> (hcount == '0)); // R2

    AST_STOP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(run) |-> stopped); // R8

    AST_DIS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !run && dis |=> !run); // R9

    AST_SOF_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        sof |=> !sof); // R10
endmodule

bind lcd_raster_gen lcd_raster_chk #(.CW(CW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run_w),
    .dis     (ctl_disable_i),
    .hcount  (hcount_o),
    .vcount  (vcount_o),
    .htot    (tot_w[0]),
    .de      (de_o),
    .de_pol  (pol_cfg_i[2]),
    .sof     (sof_o),
    .stopped (stopped_o)
);

// File: tb/lcd_raster_gen_tb.sv
// Scoreboard bench: a driver task queues the predicted value of every pixel.
// A monitor pops and compares one entry per running cycle.
module lcd_raster_gen_tb;
    localparam int CW = 10;

    typedef struct packed {
        logic [CW-1:0] hc;
        logic [CW-1:0] vc;
        logic hs, vs, de, sof, eof;
    } pix_t;

    logic clk = 1'b0, rst_n = 1'b0;
    logic en = 0, dis = 0, clr = 0, sof_en = 0, eof_en = 0;
    logic [2:0]  pol = 3'b000;
    logic [15:0] hsl = 0, vsl = 0;
    logic [31:0] tot = 0, hwin = 0, vwin = 0;
    logic hs, vs, de, sof, eof, stopped;
    logic [CW-1:0] hc, vc;

    int total = 0, bad = 0;
    bit mon_on = 0;
    pix_t q[$];

    always #10 clk = ~clk;

    lcd_raster_gen #(.CW(CW)) u_dut (
        .clk(clk), .rst_n(rst_n), .ctl_enable_i(en), .ctl_disable_i(dis),
        .status_clr_i(clr), .sof_irq_en_i(sof_en), .eof_irq_en_i(eof_en),
        .pol_cfg_i(pol), .hsync_len_i(hsl), .vsync_len_i(vsl),
        .totals_i(tot), .hwin_i(hwin), .vwin_i(vwin),
        .hsync_o(hs), .vsync_o(vs), .de_o(de), .hcount_o(hc), .vcount_o(vc),
        .sof_o(sof), .eof_o(eof), .stopped_o(stopped)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Monitor: compare one queued pixel per cycle while the raster runs
    always @(negedge clk) begin
        if (mon_on && q.size() > 0) begin
            pix_t e;
            e = q.pop_front();
            check(hc == e.hc && vc == e.vc, "R2 counters", int'({hc, vc}), int'({e.hc, e.vc}));
            check(hs == e.hs, "R3/R5 hsync", int'(hs), int'(e.hs));
            check(vs == e.vs, "R3/R5 vsync", int'(vs), int'(e.vs));
            check(de == e.de, "R4/R5 de", int'(de), int'(e.de));
            check(sof == e.sof && eof == e.eof, "R10 pulses", int'({sof, eof}), int'({e.sof, e.eof}));
        end
    end

    // Checks that the block is at rest with its outputs at the idle levels
    task automatic check_idle(input string req);
        check(hc == 0 && vc == 0, req, int'({hc, vc}), 0);
        check({de, vs, hs} == pol, req, int'({de, vs, hs}), int'(pol));
        check(!sof && !eof, req, int'({sof, eof}), 0);
    endtask

    // Driver: program the timing, queue the predicted frames, run, stop late in the last frame
    task automatic scenario(input logic [15:0] hs_w, vs_w, input logic [31:0] t, hw, vw,
                            input logic [2:0] p, input bit s_en, e_en, input int frames);
        int ht, vt, hsw, vsw, hds, hde, vds, vde, flen;
        ht = int'(t[25:16]);  vt = int'(t[9:0]);        // R11 masking
        hsw = int'(hs_w[9:0]); vsw = int'(vs_w[9:0]);
        hds = int'(hw[25:16]); hde = int'(hw[9:0]);
        vds = int'(vw[25:16]); vde = int'(vw[9:0]);
        flen = ht * vt;
        @(negedge clk); #2;
        hsl = hs_w; vsl = vs_w; tot = t; hwin = hw; vwin = vw; pol = p;
        sof_en = s_en; eof_en = e_en;
        for (int f = 0; f < frames; f++)
            for (int v = 0; v < vt; v++)
                for (int h = 0; h < ht; h++) begin
                    pix_t e;
                    e.hc = CW'(h); e.vc = CW'(v);
                    e.hs = (h < hsw) ^ p[0];
                    e.vs = (v < vsw) ^ p[1];
                    e.de = ((h >= hds && h < hde) && (v >= vds && v < vde)) ^ p[2];
                    e.sof = s_en && h == 0 && v == 0;
                    e.eof = e_en && h == ht - 1 && v == vt - 1;
                    q.push_back(e);
                end
        @(negedge clk);
        check_idle("R5 idle polarity");
        #2 en = 1;                                    // R6 start
        @(posedge clk);
        mon_on = 1;
        while (q.size() > flen / 2) @(posedge clk);
        @(negedge clk); #2 dis = 1;                   // R7 mid-frame disable
        while (q.size() != 0) @(posedge clk);
        mon_on = 0;
        @(negedge clk);
        check(stopped == 1'b1, "R8 stopped set", int'(stopped), 1);
        check_idle("R7 idle after frame");
        for (int i = 0; i < 4; i++) begin             // R9 enable held with disable
            @(negedge clk);
            check(hc == 0 && vc == 0, "R9 no restart", int'(hc), 0);
            check(stopped == 1'b1, "R8 stopped held", int'(stopped), 1);
        end
        #2 en = 0; clr = 1;
        @(negedge clk); #2 clr = 0; dis = 0;
        check(stopped == 1'b0, "R8 stopped cleared", int'(stopped), 0);
    endtask

    // Watchdog
    initial begin
        #(20 * 100000);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #2 rst_n = 1;
        @(negedge clk);
        check(stopped == 1'b0, "R1 stopped", int'(stopped), 0);
        check_idle("R1 reset idle");
        // Two frames, all positive, both pulses
        scenario(16'd2, 16'd1, {16'd12, 16'd6}, {16'd3, 16'd9}, {16'd2, 16'd5},
                 3'b000, 1'b1, 1'b1, 2);
        // Junk in the upper field bits (R11), all outputs inverted, EOF only
        scenario(16'h0401, 16'hFC02, {16'hFC0A, 16'h0405}, {16'h0402, 16'hFC08},
                 {16'h0803, 16'h0404}, 3'b111, 1'b0, 1'b1, 1);
        // Mixed polarity, SOF only
        scenario(16'd3, 16'd1, {16'd16, 16'd4}, {16'd4, 16'd14}, {16'd1, 16'd4},
                 3'b101, 1'b1, 1'b0, 2);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule